// File: doc/BRIEF.md
# Synchronous burst SRAM cycle controller

This block sits in front of a small on-chip memory array and behaves like the control front end of a synchronous burst SRAM. On every rising clock edge it looks at three chip selects, a doze input, two address strobes, a step input and a set of write controls. It decides what kind of cycle the edge starts: idle/deselected, doze, a new burst, the next beat of a burst, or a repeated beat. Each burst beat is a read or a write. It keeps a burst address register, writes the byte lanes that the write controls pick, and captures read data. It also produces the enable for the shared data bus.

The two strobes have different priority. The processor strobe only counts when the first select is active, and it always starts a read. The controller strobe starts a burst that may be a write. A burst advances through four consecutive words. The two low address bits count up and wrap, and the upper bits stay fixed. The bus enable follows the output-enable pin without a clock, but only while the registered cycle is a read.

The interface is a plain pin-level SRAM interface, sampled every clock, so there is no valid/ready handshake. Read data is registered on the edge that performs the read and stays until the next read.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While `doze` is 1 at an edge, the next `cycle_kind` is 1 (doze), nothing is written, any live burst ends, and `bus_drive` is 0.
- R2: If the block is not selected (`sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1) and a cycle is started at an edge, `cycle_kind` becomes 0 (deselect) and any live burst ends. A cycle is started by `ctl_stb_n`=0, or by `cpu_stb_n`=0 together with `sel_a_n`=0. When `sel_a_n`=1, the processor strobe is ignored.
- R3: If the block is selected and `cpu_stb_n`=0, the edge starts a read burst at `addr` (`cycle_kind`=2), whatever the write controls show.
- R4: If the block is selected, `cpu_stb_n`=1 (or ignored) and `ctl_stb_n`=0, the edge starts a burst at `addr`. It is a write (`cycle_kind`=3) when the merged write is active and a read (`cycle_kind`=2) otherwise.
- R5: If both strobes are inactive, a burst is live and `step_n`=0, the burst moves on (`cycle_kind`=5 write, 4 read). The two low bits of `burst_addr` add one modulo 4 and the upper bits stay the same.
- R6: If both strobes are inactive, a burst is live and `step_n`=1, the beat repeats at the same `burst_addr` (`cycle_kind`=7 write, 6 read).
- R7: The merged write is active when `all_wr_n`=0, or when `lane_wr_en_n`=0 and some bit of `lane_wr_n` is 0. On a write beat, `all_wr_n`=0 writes every byte lane. Otherwise lane i (`wdata[8i+7:8i]`) is written only if `lane_wr_n[i]`=0. A read beat loads the addressed word into `rdata` at that edge, and `rdata` keeps it until the next read.
- R8: `bus_drive` is 1 only when the registered cycle is a read (2, 4 or 6) and `out_en_n`=0. It follows `out_en_n` without waiting for a clock edge, and a write cycle masks it.
- R9: If both strobes are inactive and no burst is live (after reset, a deselect or a doze), `cycle_kind` is 0.
- R10: After reset, `cycle_kind`=0, `burst_addr`=0, `rdata`=0, `bus_drive`=0, and every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| doze | input | 1 | Sleep request, active high |
| sel_a_n | input | 1 | Select A, active low; gates the processor strobe |
| sel_b | input | 1 | Select B, active high |
| sel_c_n | input | 1 | Select C, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| all_wr_n | input | 1 | Write-all-lanes control, active low |
| lane_wr_en_n | input | 1 | Byte-lane write enable, active low |
| lane_wr_n | input | NB | Per-lane write select, active low |
| addr | input | AW | External word address |
| wdata | input | 8*NB | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 8*NB | Registered read data |
| bus_drive | output | 1 | Data bus drive enable |
| cycle_kind | output | 3 | Registered cycle classification |
| burst_addr | output | AW | Word address of the current beat |

## Verification
Two functions can meet in one edge, and the bench provokes both meetings on purpose. First, the processor strobe can arrive while the write controls ask for a write. The bench drives `cpu_stb_n` low together with `all_wr_n` low and expects a read beat, unchanged memory and a driven bus. Second, the output enable can be low during a write beat. The bench toggles `out_en_n` between edges and checks that `bus_drive` stays low on writes and follows the pin on reads. It also sends a low processor strobe with select A high, which must continue the burst instead of starting one. Every clock is compared against a behavioural model.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_DOZE     = 3'd1,
    CYC_BEGIN_RD = 3'd2,
    CYC_BEGIN_WR = 3'd3,
    CYC_NEXT_RD  = 3'd4,
    CYC_NEXT_WR  = 3'd5,
    CYC_HOLD_RD  = 3'd6,
    CYC_HOLD_WR  = 3'd7
  } cyc_e;

  typedef enum logic [1:0] {
    ADR_KEEP = 2'd0,
    ADR_LOAD = 2'd1,
    ADR_STEP = 2'd2
  } adr_op_e;

  function automatic logic cyc_is_read(cyc_e k);
    return (k == CYC_BEGIN_RD) || (k == CYC_NEXT_RD) || (k == CYC_HOLD_RD);
  endfunction

  function automatic logic cyc_is_write(cyc_e k);
    return (k == CYC_BEGIN_WR) || (k == CYC_NEXT_WR) || (k == CYC_HOLD_WR);
  endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          doze,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          cpu_stb_n,
  input  logic          ctl_stb_n,
  input  logic          step_n,
  input  logic          all_wr_n,
  input  logic          lane_wr_en_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic          burst_live,
  output cyc_e          kind,
  output adr_op_e       adr_op,
  output logic [NB-1:0] lane_we
);
  logic merged_wr;
  logic selected;
  logic cpu_go;

  assign merged_wr = ~all_wr_n | (~lane_wr_en_n & ~(&lane_wr_n));
  assign selected  = ~sel_a_n & sel_b & ~sel_c_n;
  assign cpu_go    = ~cpu_stb_n & ~sel_a_n;

  always_comb begin
    kind   = CYC_DESEL;
    adr_op = ADR_KEEP;
    if (doze) begin
      kind = CYC_DOZE;
    end else if (cpu_go) begin
      if (selected) begin
        kind   = CYC_BEGIN_RD;
        adr_op = ADR_LOAD;
      end
    end else if (!ctl_stb_n) begin
      if (selected) begin
        kind   = merged_wr ? CYC_BEGIN_WR : CYC_BEGIN_RD;
        adr_op = ADR_LOAD;
      end
    end else if (burst_live) begin
      if (!step_n) begin
        kind   = merged_wr ? CYC_NEXT_WR : CYC_NEXT_RD;
        adr_op = ADR_STEP;
      end else begin
        kind   = merged_wr ? CYC_HOLD_WR : CYC_HOLD_RD;
      end
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_we[i] = cyc_is_write(kind) & (~all_wr_n | (~lane_wr_en_n & ~lane_wr_n[i]));
  end
endmodule

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq
  import bsram_pkg::*;
#(
  parameter int AW = 4,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  adr_op_e       adr_op,
  input  logic          end_burst,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cur_addr,
  output logic          live
);
  localparam int HI = AW - BB;

  logic [BB-1:0] low_next;
  assign low_next = cur_addr[BB-1:0] + BB'(1);

  always_comb begin
    unique case (adr_op)
      ADR_LOAD: acc_addr = ext_addr;
      ADR_STEP: acc_addr = {cur_addr[AW-1 -: HI], low_next};
      default:  acc_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      live     <= 1'b0;
    end else begin
      cur_addr <= acc_addr;
      if (adr_op == ADR_LOAD) live <= 1'b1;
      else if (end_burst)     live <= 1'b0;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   acc_addr,
  input  logic [NB-1:0]   lane_we,
  input  logic            rd_en,
  input  logic [8*NB-1:0] wdata,
  output logic [8*NB-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        rdata[8*b +: 8] <= '0;
      end else begin
        if (lane_we[b]) mem[acc_addr] <= wdata[8*b +: 8];
        if (rd_en)      rdata[8*b +: 8] <= mem[acc_addr];
      end
    end
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BB = 2,
  localparam int DW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          doze,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          cpu_stb_n,
  input  logic          ctl_stb_n,
  input  logic          step_n,
  input  logic          all_wr_n,
  input  logic          lane_wr_en_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          out_en_n,
  output logic [DW-1:0] rdata,
  output logic          bus_drive,
  output logic [2:0]    cycle_kind,
  output logic [AW-1:0] burst_addr
);
  cyc_e          kind_d, kind_q;
  adr_op_e       adr_op;
  logic [NB-1:0] lane_we;
  logic          live;
  logic [AW-1:0] acc_addr;

  bsram_decode #(.NB(NB)) u_decode (
    .doze(doze), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .burst_live(live), .kind(kind_d), .adr_op(adr_op), .lane_we(lane_we)
  );

  bsram_addr_seq #(.AW(AW), .BB(BB)) u_seq (
    .clk(clk), .rst_n(rst_n), .adr_op(adr_op),
    .end_burst((kind_d == CYC_DESEL) || (kind_d == CYC_DOZE)),
    .ext_addr(addr), .acc_addr(acc_addr), .cur_addr(burst_addr), .live(live)
  );

  bsram_array #(.AW(AW), .NB(NB)) u_array (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .lane_we(lane_we),
    .rd_en(cyc_is_read(kind_d)), .wdata(wdata), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= CYC_DESEL;
    else        kind_q <= kind_d;
  end

  assign cycle_kind = kind_q;
  assign bus_drive  = cyc_is_read(kind_q) & ~out_en_n;
endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          doze,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          cpu_stb_n,
  input logic          ctl_stb_n,
  input logic          all_wr_n,
  input logic          lane_wr_en_n,
  input logic [NB-1:0] lane_wr_n,
  input logic [AW-1:0] addr,
  input logic          out_en_n,
  input logic          bus_drive,
  input logic [2:0]    cycle_kind,
  input logic [AW-1:0] burst_addr
);
  logic chip_on, wr_req;
  assign chip_on = !sel_a_n && sel_b && !sel_c_n;
  assign wr_req  = !all_wr_n || (!lane_wr_en_n && (lane_wr_n != {NB{1'b1}}));

  p_doze_r1: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> (cycle_kind == 3'd1) && !bus_drive);

  p_unselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && ((!sel_a_n && !cpu_stb_n) || !ctl_stb_n) && !chip_on) |=> cycle_kind == 3'd0);

  p_cpu_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && chip_on && !cpu_stb_n) |=> (cycle_kind == 3'd2) && (burst_addr == $past(addr)));

  p_ctl_begin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && chip_on && cpu_stb_n && !ctl_stb_n)
      |=> (cycle_kind == ($past(wr_req) ? 3'd3 : 3'd2)) && (burst_addr == $past(addr)));

  p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_kind == 3'd4 || cycle_kind == 3'd5)
      |-> (burst_addr[BB-1:0] == BB'($past(burst_addr[BB-1:0]) + BB'(1)))
       && (burst_addr[AW-1:BB] == $past(burst_addr[AW-1:BB])));

  p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_kind == 3'd6 || cycle_kind == 3'd7) |-> $stable(burst_addr));

  p_drive_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> !out_en_n && (cycle_kind == 3'd2 || cycle_kind == 3'd4 || cycle_kind == 3'd6));
endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.AW(AW), .NB(NB), .BB(BB)) u_chk (
  .clk(clk), .rst_n(rst_n), .doze(doze), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
  .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
  .addr(addr), .out_en_n(out_en_n), .bus_drive(bus_drive),
  .cycle_kind(cycle_kind), .burst_addr(burst_addr)
);

// File: tb/burst_sram_ctrl_tb.sv
module burst_sram_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int DW = 8 * NB;

  logic clk = 0, rst_n = 0;
  logic doze = 0, sel_a_n = 1, sel_b = 1, sel_c_n = 0;
  logic cpu_stb_n = 1, ctl_stb_n = 1, step_n = 1;
  logic all_wr_n = 1, lane_wr_en_n = 1, out_en_n = 1;
  logic [NB-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic bus_drive;
  logic [2:0] cycle_kind;
  logic [AW-1:0] burst_addr;

  int errors = 0, checks = 0;
  bit reported = 0;

  int m_kind = 0;
  bit m_live = 0;
  int m_addr = 0;
  logic [DW-1:0] m_rd = '0;
  logic [DW-1:0] m_mem [16];
  string m_tag = "R10";

  always #(CLK_P/2) clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .doze(doze), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
    .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .bus_drive(bus_drive), .cycle_kind(cycle_kind),
    .burst_addr(burst_addr)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic bit is_rd(int k);
    return k == 2 || k == 4 || k == 6;
  endfunction

  // Reference model of one edge, from the requirement text.
  task automatic model_edge();
    bit wr, on;
    wr = !all_wr_n || (!lane_wr_en_n && lane_wr_n != 4'hF);
    on = !sel_a_n && sel_b && !sel_c_n;
    if (doze) begin
      m_kind = 1; m_live = 0; m_tag = "R1";
    end else if ((!cpu_stb_n && !sel_a_n) || !ctl_stb_n) begin
      if (!on) begin
        m_kind = 0; m_live = 0; m_tag = "R2";
      end else begin
        m_addr = addr; m_live = 1;
        if (!cpu_stb_n && !sel_a_n) begin m_kind = 2; m_tag = "R3"; end
        else begin m_kind = wr ? 3 : 2; m_tag = "R4"; end
      end
    end else if (!m_live) begin
      m_kind = 0; m_tag = "R9";
    end else if (!step_n) begin
      m_addr = (m_addr & 12) | ((m_addr + 1) % 4);
      m_kind = wr ? 5 : 4; m_tag = "R5";
    end else begin
      m_kind = wr ? 7 : 6; m_tag = "R6";
    end
    if (m_kind == 3 || m_kind == 5 || m_kind == 7)
      for (int b = 0; b < NB; b++)
        if (!all_wr_n || (!lane_wr_en_n && !lane_wr_n[b]))
          m_mem[m_addr][8*b +: 8] = wdata[8*b +: 8];
    if (is_rd(m_kind)) m_rd = m_mem[m_addr];
  endtask

  task automatic compare_all();
    check(m_tag, "cycle_kind", cycle_kind, m_kind);
    check("R5", "burst_addr", burst_addr, m_addr);
    check("R7", "rdata", rdata, m_rd);
    check("R8", "bus_drive", bus_drive, is_rd(m_kind) && !out_en_n);
  endtask

  task automatic step(bit dz, bit a, bit b, bit c, bit p, bit q, bit s,
                      bit g, bit e, logic [3:0] bw, logic [3:0] ad, bit oe,
                      logic [31:0] wd);
    @(negedge clk);
    doze = dz; sel_a_n = a; sel_b = b; sel_c_n = c; cpu_stb_n = p; ctl_stb_n = q;
    step_n = s; all_wr_n = g; lane_wr_en_n = e; lane_wr_n = bw; addr = ad;
    out_en_n = oe; wdata = wd;
    @(posedge clk);
    model_edge();
    #1 compare_all();
    out_en_n = ~out_en_n;  // asynchronous enable between edges (R8)
    #1 check("R8", "bus_drive after oe toggle", bus_drive, is_rd(m_kind) && !out_en_n);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1; out_en_n = 0;
    #1;
    check("R10", "reset cycle_kind", cycle_kind, 0);
    check("R10", "reset burst_addr", burst_addr, 0);
    check("R10", "reset rdata", rdata, 0);
    check("R10", "reset bus_drive", bus_drive, 0);

    // R9: idle with no live burst
    step(0,0,1,0, 1,1, 0, 1,1,4'hF, 4'h3, 0, 0);
    // R10: memory cleared, read address 9
    step(0,0,1,0, 0,1, 1, 1,1,4'hF, 4'h9, 0, 0);
    // R4 write burst at 6 with all lanes, then R5 steps with lane selects (wrap 7->4)
    step(0,0,1,0, 1,0, 1, 0,1,4'hF, 4'h6, 0, 32'h11223344);
    step(0,0,1,0, 1,1, 0, 1,0,4'b0101, 4'h0, 0, 32'hAABBCCDD);
    step(0,0,1,0, 1,1, 0, 1,0,4'b1110, 4'h0, 1, 32'h55667788);
    // R6 suspend write, lanes ignored when lane enable high (read beat)
    step(0,0,1,0, 1,1, 1, 1,0,4'b0111, 4'h0, 0, 32'hCAFEF00D);
    step(0,0,1,0, 1,1, 1, 1,1,4'b0000, 4'h0, 0, 32'hDEADBEEF);
    // R3: processor strobe with write-all low must read
    step(0,0,1,0, 0,1, 1, 0,1,4'h0, 4'h6, 0, 32'hFFFFFFFF);
    step(0,0,1,0, 1,1, 0, 1,1,4'hF, 4'h0, 0, 0);
    step(0,0,1,0, 1,1, 0, 1,1,4'hF, 4'h0, 0, 0);
    // R2: select A high ignores processor strobe -> burst continues
    step(0,1,1,0, 0,1, 0, 1,1,4'hF, 4'h2, 0, 0);
    // R2: controller strobe while unselected, then idle (R9)
    step(0,0,0,0, 1,0, 0, 0,1,4'hF, 4'h2, 0, 32'h1);
    step(0,0,1,0, 1,1, 0, 0,1,4'hF, 4'h2, 0, 32'h1);
    // R1: doze ends a live burst
    step(0,0,1,0, 1,0, 1, 1,1,4'hF, 4'h7, 0, 0);
    step(1,0,1,0, 0,0, 0, 0,0,4'h0, 4'h1, 0, 32'h9);
    step(0,0,1,0, 1,1, 0, 0,1,4'hF, 4'h1, 0, 32'h9);

    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 6) != 0,
           ($urandom % 6) == 0, ($urandom % 4) != 0, ($urandom % 3) != 0,
           $urandom % 2, ($urandom % 4) != 0, $urandom % 2, 4'($urandom),
           4'($urandom), $urandom % 2, $urandom);
    end
    report();
  end
endmodule